// File: doc/BRIEF.md
# Module configuration EEPROM slave

This block is a 256-byte memory that sits on a two-wire serial bus as a slave. A memory module uses it to report its configuration to the host. The bus has a clock line and an open-drain data line. The block samples both lines with its own system clock. It pulls the data line low through a single enable output. Three strap inputs choose which of eight slave addresses it answers to. A write-protect input guards the upper half of the memory.

The lower 128 bytes come from a parameter image at reset and can never be changed from the bus. At reset, byte 63 is replaced by the 8-bit sum of bytes 0 to 62, so the stored checksum is always consistent with the image. The upper 128 bytes clear to zero and accept writes while write-protect is low. The host can write single bytes, read from an address it sets with a dummy write (a random read), and read onward byte by byte (a sequential read). When a stop ends a transfer that changed memory, the block models the programming interval of a real part. For a parameterised number of clock cycles it stays off the bus.

Top module: `presence_rom_slave`

## Requirements
- R1: A byte whose upper seven bits equal 1010 followed by `sel_in` (bit 0 is R/W, 1 = read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte gets no acknowledge, and the block ignores the bus until the next start.
- R2: With `wp_in` low, a data byte written to an address from 128 to 255 is stored there and reads back unchanged.
- R3: Addresses 0 to 127 never change. Data bytes sent to them are still acknowledged.
- R4: With `wp_in` high, data bytes sent to addresses 128 to 255 are acknowledged but not stored. Such a transfer starts no busy interval, so the next address byte is acknowledged at once.
- R5: After the stop that ends a transfer in which at least one byte was stored, the slave address is not acknowledged for BUSY_CYCLES clock cycles. After that it is acknowledged again.
- R6: A random read (write address byte, word address, repeated start, read address byte) returns the byte at that word address.
- R7: During a read, the internal pointer advances after every byte and wraps from 255 to 0. The read goes on while the master acknowledges and stops at the first master non-acknowledge.
- R8: After reset, byte i for i < 128 equals byte i of LOWER_INIT. The exception is byte 63, which holds the 8-bit sum of bytes 0 to 62. Bytes 128 to 255 are 0x00.
- R9: A pulse on SCL or SDA shorter than FILT_CYCLES clock cycles has no effect on the transfer.
- R10: A start condition at any point abandons the transfer in progress. The next byte is taken as an address byte, and the word pointer keeps its value.
- R11: While reset is held, and whenever no transfer is addressed to the slave, `sda_drive_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the wire |
| sda_drive_low | output | 1 | Pulls the data line low when 1, releases it when 0 |
| sel_in | input | 3 | Strap bits forming the low part of the slave address |
| wp_in | input | 1 | Write protect for bytes 128 to 255, active high |

## Verification
The assertions assume a well-formed bus. The master changes SDA only while SCL is low, except for start and stop. Each level is held for many more than FILT_CYCLES cycles. `wp_in` does not change in the middle of a byte. The bench drives the bus with quarter-bit phases of 20 clocks, which is well above the filter length. It moves `wp_in` only between transfers. Its only departures from clean levels are deliberate pulses of two clocks, which are shorter than the filter. When the bench aborts a byte with a new start, it releases SDA before raising SCL, so the start is a clean one.

// File: rtl/presence_rom_slave.sv
`timescale 1ns/1ps
module presence_rom_slave #(
  parameter int FILT_CYCLES = 20,
  parameter int BUSY_CYCLES = 3000000,
  parameter logic [1023:0] LOWER_INIT = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic [2:0] sel_in,
  input  logic       wp_in
);
  localparam int BYTES = 256;
  localparam int HALF  = BYTES / 2;
  localparam int FW    = $clog2(FILT_CYCLES + 1);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [3:0] DEV_CODE = 4'b1010;

  function automatic logic [7:0] sum_head(input logic [1023:0] img);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 63; i++) s = s + img[i*8 +: 8];
    return s;
  endfunction
  localparam logic [7:0] CSUM = sum_head(LOWER_INIT);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_WORD, ST_WDATA, ST_ACK_OUT, ST_RDATA, ST_ACK_IN} st_t;

  // input conditioning: two-flop sync, then a stability filter per line
  logic [1:0] sy1, sy2, filt;
  logic [FW-1:0] fc [2];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 2'b11; sy2 <= 2'b11; filt <= 2'b11;
      for (int g = 0; g < 2; g++) fc[g] <= '0;
    end else begin
      sy1 <= {sda_in, scl_in};
      sy2 <= sy1;
      for (int g = 0; g < 2; g++) begin
        if (sy2[g] == filt[g]) fc[g] <= '0;
        else if (fc[g] == FW'(FILT_CYCLES - 1)) begin
          filt[g] <= sy2[g];
          fc[g] <= '0;
        end else fc[g] <= fc[g] + 1'b1;
      end
    end
  end

  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_q, sda_q} <= 2'b11;
    else {scl_q, sda_q} <= {filt[0], filt[1]};

  wire scl_f     = filt[0];
  wire sda_f     = filt[1];
  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;
  wire start_det = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st, nxt;
  logic [3:0] cnt;
  logic [7:0] shreg, ptr;
  logic       more, sda_oe, wrote, busy;
  logic [BW-1:0] bcnt;
  logic [7:0] mem [BYTES];

  assign sda_drive_low = sda_oe;
  wire [7:0] rd_byte = mem[ptr];
  wire addr_hit = (shreg[7:1] == {DEV_CODE, sel_in}) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; shreg <= '0; ptr <= '0;
      more <= 1'b0; sda_oe <= 1'b0; wrote <= 1'b0; busy <= 1'b0; bcnt <= '0;
      for (int i = 0; i < BYTES; i++)
        mem[i] <= (i >= HALF) ? 8'h00 : (i == 63) ? CSUM : LOWER_INIT[i*8 +: 8];
    end else begin
      if (busy) begin
        if (bcnt == BW'(BUSY_CYCLES - 1)) begin busy <= 1'b0; bcnt <= '0; end
        else bcnt <= bcnt + 1'b1;
      end
      if (start_det) begin
        st <= ST_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
        if (wrote) begin busy <= 1'b1; bcnt <= '0; wrote <= 1'b0; end
      end else begin
        case (st)
          ST_DEV, ST_WORD, ST_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_DEV) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  nxt <= shreg[0] ? ST_RDATA : ST_WORD;
                  st <= ST_ACK_OUT;
                end else st <= ST_IDLE;
              end else if (st == ST_WORD) begin
                ptr <= shreg; sda_oe <= 1'b1; nxt <= ST_WDATA; st <= ST_ACK_OUT;
              end else begin
                if (ptr[7] && !wp_in) begin
                  mem[ptr] <= shreg;
                  wrote <= 1'b1;
                end
                ptr <= ptr + 8'd1; sda_oe <= 1'b1; nxt <= ST_WDATA; st <= ST_ACK_OUT;
              end
            end
          end
          ST_ACK_OUT: if (scl_fall) begin
            if (nxt == ST_RDATA) begin
              shreg <= rd_byte; sda_oe <= ~rd_byte[7];
            end else sda_oe <= 1'b0;
            cnt <= '0;
            st <= nxt;
          end
          ST_RDATA: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; ptr <= ptr + 8'd1; cnt <= '0; st <= ST_ACK_IN;
            end else begin
              sda_oe <= ~shreg[6]; shreg <= {shreg[6:0], 1'b0}; cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) more <= ~sda_f;
            else if (scl_fall) begin
              if (more) begin
                shreg <= rd_byte; sda_oe <= ~rd_byte[7]; cnt <= '0; st <= ST_RDATA;
              end else st <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic [HALF*8-1:0] lower_view, upper_view;
  always_comb
    for (int i = 0; i < HALF; i++) begin
      lower_view[i*8 +: 8] = mem[i];
      upper_view[i*8 +: 8] = mem[i + HALF];
    end

  // R3
  lower_locked_chk: assert property (@(posedge clk) disable iff (!rst_n) $stable(lower_view));
  // R4
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n) $past(wp_in) |-> $stable(upper_view));
  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_drive_low);
  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(bcnt) == BW'(BUSY_CYCLES - 1));
  // R10
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) start_det |=> (st == ST_DEV && !sda_drive_low));
  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) st == ST_IDLE |-> !sda_drive_low);
endmodule

// File: tb/presence_rom_slave_test.sv
`timescale 1ns/1ps
module presence_rom_slave_test;
  localparam int FILT = 4;
  localparam int BUSY = 1500;
  localparam int Q = 20;
  localparam logic [7:0] DW = 8'hAA, DR = 8'hAB;

  function automatic logic [1023:0] make_img();
    logic [1023:0] r;
    for (int i = 0; i < 128; i++) r[i*8 +: 8] = 8'((i * 13 + 7) & 255);
    return r;
  endfunction
  localparam logic [1023:0] IMG = make_img();

  // {word address, data, wp, expect stored}
  localparam logic [17:0] VEC [6] = '{
    {8'h80, 8'h11, 1'b0, 1'b1},
    {8'hFF, 8'h22, 1'b0, 1'b1},
    {8'h05, 8'h33, 1'b0, 1'b0},
    {8'h3F, 8'h44, 1'b0, 1'b0},
    {8'hC0, 8'h55, 1'b1, 1'b0},
    {8'h7F, 8'h66, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0, scl = 1, msl = 0, wp = 0;
  logic sda_drive_low;
  wire sda_line = ~(msl | sda_drive_low);
  always #2.5 clk = ~clk;

  presence_rom_slave #(.FILT_CYCLES(FILT), .BUSY_CYCLES(BUSY), .LOWER_INIT(IMG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low), .sel_in(3'b101), .wp_in(wp));

  int total = 0, fails = 0;
  logic [7:0] exp_mem [256];

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic waitc(input int n); repeat (n) @(negedge clk); endtask
  task automatic do_start(); msl = 0; waitc(Q); scl = 1; waitc(Q); msl = 1; waitc(Q); scl = 0; waitc(Q); endtask
  task automatic do_stop(); msl = 1; waitc(Q); scl = 1; waitc(Q); msl = 0; waitc(2*Q); endtask
  task automatic bit_out(input logic b); msl = ~b; waitc(Q); scl = 1; waitc(2*Q); scl = 0; waitc(Q); endtask
  task automatic bit_in(output logic b, input logic glitch);
    msl = 0; waitc(Q); scl = 1; waitc(Q/2);
    if (glitch) begin scl = 0; waitc(2); scl = 1; end
    waitc(Q/2); b = sda_line; waitc(Q); scl = 0; waitc(Q);
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b, 1'b0);
    ack = ~b;
  endtask
  task automatic recv_byte(input logic mack, input int gbit, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b, gbit == i); d[i] = b; end
    bit_out(~mack);
  endtask
  task automatic write_one(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    do_start(); send_byte(DW, acks[2]); send_byte(a, acks[1]); send_byte(d, acks[0]); do_stop();
  endtask
  task automatic read_one(input logic [7:0] a, input int gbit, output logic [7:0] d, output logic [2:0] acks);
    do_start(); send_byte(DW, acks[2]); send_byte(a, acks[1]);
    do_start(); send_byte(DR, acks[0]); recv_byte(1'b0, gbit, d); do_stop();
  endtask

  logic done = 0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic a;
    for (int i = 0; i < 256; i++) exp_mem[i] = (i < 128) ? IMG[i*8 +: 8] : 8'h00;
    exp_mem[63] = '0;
    for (int i = 0; i < 63; i++) exp_mem[63] = exp_mem[63] + exp_mem[i];

    waitc(3);
    check(sda_drive_low == 1'b0, "R11 in reset", {7'd0, sda_drive_low}, 8'h00);
    waitc(7); rst_n = 1; waitc(20);
    check(sda_drive_low == 1'b0, "R11 idle", {7'd0, sda_drive_low}, 8'h00);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] va, vd;
      va = VEC[v][17:10]; vd = VEC[v][9:2]; wp = VEC[v][1];
      waitc(Q);
      write_one(va, vd, acks);
      check(acks == 3'b111, "R2/R3/R4 write acked", {5'd0, acks}, 8'h07);
      if (VEC[v][0]) exp_mem[va] = vd;
      wp = 0;
      waitc(BUSY + 100);
      read_one(va, -1, d, acks);
      check(d == exp_mem[va], va[7] ? (VEC[v][1] ? "R4 protected" : "R2 stored") : "R3 locked", d, exp_mem[va]);
      check(acks == 3'b111, "R6 read acks", {5'd0, acks}, 8'h07);
    end

    // R8 image and checksum
    read_one(8'd63, -1, d, acks);
    check(d == exp_mem[63], "R8 checksum byte", d, exp_mem[63]);
    read_one(8'd10, -1, d, acks);
    check(d == exp_mem[10], "R8 image byte", d, exp_mem[10]);

    // R7 sequential read with wrap
    do_start(); send_byte(DW, a); send_byte(8'hFE, a);
    do_start(); send_byte(DR, a);
    check(a, "R7 read address ack", {7'd0, a}, 8'h01);
    recv_byte(1'b1, -1, d); check(d == exp_mem[8'hFE], "R7 byte FE", d, exp_mem[8'hFE]);
    recv_byte(1'b1, -1, d); check(d == exp_mem[8'hFF], "R7 byte FF", d, exp_mem[8'hFF]);
    recv_byte(1'b0, -1, d); check(d == exp_mem[8'h00], "R7 wrap to 0", d, exp_mem[8'h00]);
    do_stop();
    check(sda_drive_low == 1'b0, "R7 released after nack", {7'd0, sda_drive_low}, 8'h00);

    // R1 wrong select bits
    do_start(); send_byte(8'hA0, a); do_stop();
    check(!a, "R1 foreign address", {7'd0, a}, 8'h00);

    // R5 busy window
    write_one(8'h90, 8'h77, acks); exp_mem[8'h90] = 8'h77;
    do_start(); send_byte(DW, a); do_stop();
    check(!a, "R5 nack while busy", {7'd0, a}, 8'h00);
    waitc(BUSY + 100);
    do_start(); send_byte(DW, a); do_stop();
    check(a, "R5 ack after busy", {7'd0, a}, 8'h01);
    read_one(8'h90, -1, d, acks);
    check(d == 8'h77, "R5 written value", d, 8'h77);

    // R4 no busy after protected write
    wp = 1;
    write_one(8'hA0, 8'h99, acks);
    do_start(); send_byte(DW, a); do_stop();
    wp = 0;
    check(a, "R4 no busy window", {7'd0, a}, 8'h01);
    read_one(8'hA0, -1, d, acks);
    check(d == exp_mem[8'hA0], "R4 unchanged", d, exp_mem[8'hA0]);

    // R9 short glitch on SCL during a data bit
    read_one(8'h06, 3, d, acks);
    check(d == exp_mem[8'h06], "R9 glitch ignored", d, exp_mem[8'h06]);

    // R10 start in the middle of a data byte
    do_start(); send_byte(DW, a); send_byte(8'h80, a);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    do_start(); send_byte(DR, a);
    check(a, "R10 address after abort", {7'd0, a}, 8'h01);
    recv_byte(1'b0, -1, d); do_stop();
    check(d == exp_mem[8'h80], "R10 pointer kept", d, exp_mem[8'h80]);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule